// File: doc/BRIEF.md
# Decrementer Timer with Underflow Interrupt

This block is a down-counting timer of parameterized width, from 2 up to 64 bits. It counts down by one on every timebase tick and raises an interrupt request when it underflows. Software loads and reads the counter through a plain register port made of a write enable, write data and read data. Each loaded value is cut to the counter width and then treated as a two's-complement number, with the top bit as the sign.

A mode input selects one of two underflow behaviours. In level mode the request follows the sign of the counter. A write of a non-negative value of 3 or more drops the request. In edge mode a 0-to-1 change of the sign bit sets a sticky pending request. Only the acknowledge input clears it. In both modes a write whose signed value is below 3 raises the request at once, so a load of a tiny, zero or negative count cannot miss its interrupt.

Top module: `dec_timer`

## Requirements
- R1: A synchronous reset sets the counter to all ones (value -1), so `rd_data` reads all ones, and it drives `irq` low.
- R2: On a cycle with `tick` high and `wr_en` low, the counter decreases by one modulo 2^W. With neither input high, it holds its value.
- R3: A write stores `wr_data[W-1:0]` and takes priority over a tick in the same cycle. `rd_data` returns the counter sign-extended from bit W-1 to RW bits.
- R4: In either mode, a write whose W-bit signed value is below 3 (0, 1, 2 or any negative value) sets `irq` on the clock edge that takes the write.
- R5: In level mode (`mode`=0), a write of a non-negative value of 3 or more clears `irq`.
- R6: In level mode, a tick that moves the counter from 0 to -1 sets `irq`. Further ticks keep it set while the sign bit stays 1. A tick that wraps the counter from the most negative value to the most positive value clears it.
- R7: In edge mode (`mode`=1), a tick that turns the sign bit from 0 to 1 sets `irq`. `irq` then stays set through further ticks and through writes of values of 3 or more until `ack` is applied.
- R8: In edge mode, `ack` clears `irq` on the next edge, unless a set condition occurs in the same cycle, in which case the set wins. In level mode, `ack` has no effect.
- R9: With W equal to RW (64 bits), the sign test, the below-3 test and the read-back work across the full word. This covers writes of the most negative value, writes of the most positive value, and counting through zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase pulse; decrements the counter |
| wr_en | input | 1 | Write strobe for the counter |
| wr_data | input | RW | Value to load; the low W bits are used |
| mode | input | 1 | 0 = level underflow, 1 = edge underflow |
| ack | input | 1 | Clears a pending request in edge mode |
| rd_data | output | RW | Counter value, sign-extended |
| irq | output | 1 | Interrupt request |

## Verification
The counter and the request are both registers. A write, tick or acknowledge applied before a rising edge therefore shows up on `rd_data` and `irq` exactly one edge later, and no result is due combinationally. The bench changes inputs on the falling edge, lets one rising edge pass, and samples on the next falling edge. Each expected value is the one for that single edge. Multi-tick sequences advance one edge at a time and check after each step where the sign bit or the request may change.

// File: rtl/dec_timer.sv
`timescale 1ns/1ps
module dec_timer #(
  parameter int W  = 64,
  parameter int RW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_data,
  input  logic          mode,
  input  logic          ack,
  output logic [RW-1:0] rd_data,
  output logic          irq
);
  localparam logic [W-1:0] ONE   = W'(1);
  localparam logic [W-1:0] THREE = W'(3);
  localparam logic [W-1:0] MINV  = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] cnt, cnt_dec, wr_val;
  logic         wr_small, irq_n;

  assign wr_val   = wr_data[W-1:0];
  assign wr_small = wr_val[W-1] || (wr_val < THREE);
  assign cnt_dec  = cnt - ONE;

  always_comb begin
    irq_n = irq;
    if (mode && ack) irq_n = 1'b0;
    if (wr_en) begin
      if (wr_small)   irq_n = 1'b1;
      else if (!mode) irq_n = 1'b0;
    end else if (tick) begin
      if (!cnt[W-1] && cnt_dec[W-1])             irq_n = 1'b1;
      else if (!mode && cnt[W-1] && !cnt_dec[W-1]) irq_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '1;
      irq <= 1'b0;
    end else begin
      if (wr_en)     cnt <= wr_val;
      else if (tick) cnt <= cnt_dec;
      irq <= irq_n;
    end
  end

  generate
    if (RW == W) begin : g_full
      assign rd_data = cnt;
    end else begin : g_ext
      assign rd_data = {{(RW-W){cnt[W-1]}}, cnt};
    end
  endgenerate

  p_dec_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_en) |=> (cnt == $past(cnt) - ONE));
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_en) |=> $stable(cnt));
  p_wr_prio_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (rd_data[W-1:0] == $past(wr_data[W-1:0])));
  p_small_wr_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ($signed(wr_data[W-1:0]) < $signed(THREE))) |=> irq);
  p_lvl_clr_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !mode && !wr_data[W-1] && (wr_data[W-1:0] >= THREE)) |=> !irq);
  p_lvl_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !mode && irq && cnt != MINV) |=> irq);
  p_edge_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (mode && irq && !ack) |=> irq);
  p_ack_r8: assert property (@(posedge clk) disable iff (rst)
    (mode && ack && !wr_en && !(tick && cnt == '0)) |=> !irq);
endmodule

// File: tb/dec_timer_tb_top.sv
`timescale 1ns/1ps
module dec_timer_tb_top;
  localparam int RW = 64;
  localparam int WS = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b0, wr_en = 1'b0, mode = 1'b0, ack = 1'b0;
  logic [RW-1:0] wr_data = '0;
  logic [RW-1:0] rd_s, rd_f;
  logic          irq_s, irq_f;
  int            checks = 0, errors = 0;
  bit            done = 0;

  always #2.5 clk = ~clk;

  dec_timer #(.W(WS), .RW(RW)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
    .mode(mode), .ack(ack), .rd_data(rd_s), .irq(irq_s));

  dec_timer #(.W(RW), .RW(RW)) dut_full_i (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
    .mode(mode), .ack(ack), .rd_data(rd_f), .irq(irq_f));

  task automatic chk(input string req, input string what,
                     input logic [RW-1:0] act, input logic [RW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [RW-1:0] d,
                     input logic tk, input logic ak);
    wr_en = we; wr_data = d; tick = tk; ack = ak;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0; ack = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "rd", rd_s, '1);
    chk("R1", "irq", {63'd0, irq_s}, 64'd0);
    chk("R1", "rd_full", rd_f, '1);
  endtask

  task automatic t_count;
    mode = 1'b0;
    cyc(1, 64'd100, 0, 0);
    chk("R5", "irq after 100", {63'd0, irq_s}, 64'd0);
    for (int i = 0; i < 5; i++) cyc(0, '0, 1, 0);
    chk("R2", "after 5 ticks", rd_s, 64'd95);
    for (int i = 0; i < 3; i++) cyc(0, '0, 0, 0);
    chk("R2", "idle hold", rd_s, 64'd95);
  endtask

  task automatic t_write;
    mode = 1'b0;
    cyc(1, 64'h1234_5678_9ABC_8001, 1, 0);
    chk("R3", "truncate+signext", rd_s, 64'hFFFF_FFFF_FFFF_8001);
    chk("R4", "neg write irq", {63'd0, irq_s}, 64'd1);
    cyc(1, 64'h0000_0000_0001_7FFF, 0, 0);
    chk("R3", "positive readback", rd_s, 64'h7FFF);
    chk("R5", "clear on big write", {63'd0, irq_s}, 64'd0);
  endtask

  task automatic t_small;
    mode = 1'b0;
    cyc(1, 64'd2, 0, 0);
    chk("R4", "level write 2", {63'd0, irq_s}, 64'd1);
    cyc(1, 64'd3, 0, 0);
    chk("R5", "level write 3", {63'd0, irq_s}, 64'd0);
    mode = 1'b1;
    cyc(1, 64'd0, 0, 0);
    chk("R4", "edge write 0", {63'd0, irq_s}, 64'd1);
    cyc(1, 64'd3, 0, 0);
    chk("R7", "edge write 3 keeps", {63'd0, irq_s}, 64'd1);
    cyc(0, '0, 0, 1);
    chk("R8", "edge ack", {63'd0, irq_s}, 64'd0);
  endtask

  task automatic t_level_count;
    mode = 1'b0;
    cyc(1, 64'd3, 0, 0);
    for (int i = 0; i < 3; i++) cyc(0, '0, 1, 0);
    chk("R6", "at zero", rd_s, 64'd0);
    chk("R6", "irq at zero", {63'd0, irq_s}, 64'd0);
    cyc(0, '0, 1, 0);
    chk("R6", "count to -1", rd_s, '1);
    chk("R6", "irq at -1", {63'd0, irq_s}, 64'd1);
    cyc(0, '0, 1, 0);
    chk("R6", "irq stays", {63'd0, irq_s}, 64'd1);
    cyc(1, 64'h8000, 0, 0);
    chk("R3", "min neg read", rd_s, 64'hFFFF_FFFF_FFFF_8000);
    cyc(0, '0, 1, 0);
    chk("R6", "wrap to max", rd_s, 64'h7FFF);
    chk("R6", "wrap clears", {63'd0, irq_s}, 64'd0);
  endtask

  task automatic t_edge;
    mode = 1'b1;
    cyc(1, 64'd5, 0, 1);
    chk("R8", "ack with big write", {63'd0, irq_s}, 64'd0);
    for (int i = 0; i < 5; i++) cyc(0, '0, 1, 0);
    chk("R7", "at zero", {63'd0, irq_s}, 64'd0);
    cyc(0, '0, 1, 0);
    chk("R7", "0->1 sets", {63'd0, irq_s}, 64'd1);
    cyc(0, '0, 1, 0);
    cyc(1, 64'd100, 0, 0);
    chk("R7", "sticky", {63'd0, irq_s}, 64'd1);
    cyc(0, '0, 0, 1);
    chk("R8", "ack clears", {63'd0, irq_s}, 64'd0);
    cyc(1, 64'd0, 0, 1);
    chk("R8", "set beats ack", {63'd0, irq_s}, 64'd1);
    cyc(0, '0, 0, 1);
    cyc(1, 64'd0, 0, 0);
    cyc(0, '0, 1, 1);
    chk("R8", "tick set beats ack", {63'd0, irq_s}, 64'd1);
    mode = 1'b0;
    cyc(1, 64'hFFFF_FFFF_FFFF_FFFB, 0, 0);
    cyc(0, '0, 0, 1);
    chk("R8", "level ack ignored", {63'd0, irq_s}, 64'd1);
  endtask

  task automatic t_full;
    mode = 1'b0;
    cyc(1, 64'h7FFF_FFFF_FFFF_FFFF, 0, 0);
    chk("R9", "max pos irq", {63'd0, irq_f}, 64'd0);
    cyc(0, '0, 1, 0);
    chk("R9", "max pos tick", rd_f, 64'h7FFF_FFFF_FFFF_FFFE);
    cyc(1, 64'h8000_0000_0000_0000, 0, 0);
    chk("R9", "min neg irq", {63'd0, irq_f}, 64'd1);
    chk("R9", "min neg read", rd_f, 64'h8000_0000_0000_0000);
    cyc(1, 64'd3, 0, 0);
    chk("R9", "write 3 clears", {63'd0, irq_f}, 64'd0);
    for (int i = 0; i < 4; i++) cyc(0, '0, 1, 0);
    chk("R9", "count to -1", rd_f, '1);
    chk("R9", "irq at -1", {63'd0, irq_f}, 64'd1);
    cyc(1, 64'd0, 0, 0);
    chk("R9", "write 0 irq", {63'd0, irq_f}, 64'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_count();
    t_write();
    t_small();
    t_level_count();
    t_edge();
    t_full();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule